// File: doc/BRIEF.md
# DMA Chain Reload Unit

This unit sits beside a four-channel DMA register file and refills it when a chained block transfer completes, so that the next block can be started without the processor rewriting any registers. It watches a completion pulse together with the number of the channel that finished, reads the current address and count registers of all four channels, and reads a four-bit chaining control field. When chaining is armed and the finished channel's count has reached zero, the unit issues one cycle of per-channel write strobes and the values to be written back into the register file.

Two reload patterns exist. In the plain pattern, channel 3 acts as a holding slot: its address and count are copied into a selectable chain channel. In the ring pattern, the register sets of the chain channel and its three neighbours shift one step around the ring towards the chain channel. The slot that is vacated at the end of the ring gets a zero count, so it cannot run again until it is reloaded. Starting the next transfer and any bus handshake are left to the surrounding logic. Two elaboration parameters can remove chaining entirely or remove only the ring pattern.

The control field keeps a fixed layout: bit 0 arms chaining, bits [2:1] select the chain channel, and bit 3 picks the ring pattern.

Top module: `dma_chain_reload`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every address and count write strobe is low.
- R2: A cycle that has no completion pulse produces no write strobe in the following cycle.
- R3: A completion pulse raises strobes only when control bit 0 is 1 and the count register of the reported channel (doneChan) holds zero. In every other case no strobe rises.
- R4: With control bit 3 at 0, a chaining event writes the address and count of channel 3 into the chain channel (control bits [2:1]). Exactly that one channel's address strobe and count strobe are raised.
- R5: With control bit 3 at 1, call the chain channel s. A chaining event writes channel (s+3) mod 4 into s, (s+2) mod 4 into (s+3) mod 4, and (s+1) mod 4 into (s+2) mod 4. Both address and count move, and those three channels' address and count strobes are raised.
- R6: In the ring pattern, the count of channel (s+1) mod 4 is written with zero, and no address strobe is raised for that channel.
- R7: Every write for one event is presented in the same single cycle, the cycle after the completion pulse. The values are the register contents sampled with the pulse, and a pulse in each of two consecutive cycles yields two consecutive write cycles.
- R8: With parameter ROTATE_EN at 0, control bit 3 has no effect and every chaining event uses the R4 pattern.
- R9: With parameter CHAIN_EN at 0, control bits 0 to 3 have no effect and no strobe is ever raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| doneValid | input | 1 | One-cycle pulse: a transfer on doneChan finished |
| doneChan | input | 2 | Number of the channel that finished |
| chainCtrl | input | 4 | Bit 0 arm, bits [2:1] chain channel, bit 3 ring pattern |
| addrFlat | input | 4*AW | Current address registers, channel k at [k*AW +: AW] |
| cntFlat | input | 4*CW | Current count registers, channel k at [k*CW +: CW] |
| addrWe | output | 4 | Per-channel address write strobe |
| addrWr | output | 4*AW | Address write values, channel k at [k*AW +: AW] |
| cntWe | output | 4 | Per-channel count write strobe |
| cntWr | output | 4*CW | Count write values, channel k at [k*CW +: CW] |

## Verification
The hardest case to reach from the ports is a ring event whose chain channel makes the shift wrap past channel 3. Such an event also needs a zero count on the reporting channel, a different completion pulse on the very next cycle, and distinct contents in all four channels so that any misrouted source shows up. The stimulus fills every channel with fresh random addresses and counts on every cycle, and it forces the reported channel's count to zero in directed sweeps over all four chain channels in both patterns. It then issues back-to-back pulses with the arm bit and the count condition switched on and off. The same stimulus drives three instances, one with each parameter setting, and each instance is compared every cycle against a behavioural model.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int NUM_CH = 4;
  localparam int SEL_W  = 2;

  // control field bit positions (decoded by neighbour logic, so they are fixed)
  localparam int CTL_ARM    = 0;
  localparam int CTL_SEL_LO = 1;
  localparam int CTL_SEL_HI = 2;
  localparam int CTL_RING   = 3;

  typedef struct packed {
    logic             fire;
    logic             rotate;
    logic [SEL_W-1:0] sel;
  } chainStrb_t;
endpackage

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int CW        = 16,
  parameter int CHAIN_EN  = 1,
  parameter int ROTATE_EN = 1
) (
  input  logic                 doneValid,
  input  logic [SEL_W-1:0]     doneChan,
  input  logic [3:0]           chainCtrl,
  input  logic [NUM_CH*CW-1:0] cntFlat,
  output chainStrb_t           strb
);
  logic [CW-1:0] doneCount;
  logic          countZero;

  always_comb begin
    doneCount = cntFlat[doneChan*CW +: CW];
    countZero = (doneCount == '0);
  end

  generate
    if (CHAIN_EN != 0) begin : g_chain
      logic ringAllowed;
      if (ROTATE_EN != 0) begin : g_ring
        assign ringAllowed = chainCtrl[CTL_RING];
      end else begin : g_noring
        assign ringAllowed = 1'b0;
      end
      always_comb begin
        strb.fire   = doneValid && chainCtrl[CTL_ARM] && countZero;
        strb.rotate = ringAllowed;
        strb.sel    = chainCtrl[CTL_SEL_HI:CTL_SEL_LO];
      end
    end else begin : g_nochain
      assign strb = '0;
    end
  endgenerate
endmodule

// File: rtl/dma_chain_dpath.sv
module dma_chain_dpath
  import dma_chain_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  chainStrb_t           strb,
  input  logic [NUM_CH*AW-1:0] addrFlat,
  input  logic [NUM_CH*CW-1:0] cntFlat,
  output logic [NUM_CH-1:0]    addrWe,
  output logic [NUM_CH*AW-1:0] addrWr,
  output logic [NUM_CH-1:0]    cntWe,
  output logic [NUM_CH*CW-1:0] cntWr
);
  localparam logic [SEL_W-1:0] HOLD_CH = SEL_W'(NUM_CH - 1);

  logic [AW-1:0] addrIn [NUM_CH];
  logic [CW-1:0] cntIn  [NUM_CH];
  logic [AW-1:0] nAddr  [NUM_CH];
  logic [CW-1:0] nCnt   [NUM_CH];
  logic [AW-1:0] addrQ  [NUM_CH];
  logic [CW-1:0] cntQ   [NUM_CH];
  logic [NUM_CH-1:0] nAddrWe, nCntWe;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
      assign addrIn[g] = addrFlat[g*AW +: AW];
      assign cntIn[g]  = cntFlat[g*CW +: CW];
      assign addrWr[g*AW +: AW] = addrQ[g];
      assign cntWr[g*CW +: CW]  = cntQ[g];
    end
  endgenerate

  // slot k relative to the chain channel: rel = k - sel (mod 4)
  // ring: rel 1 is the vacated slot, every other slot takes its lower neighbour
  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      logic [SEL_W-1:0] rel;
      logic [SEL_W-1:0] src;
      rel = SEL_W'(k) - strb.sel;
      src = SEL_W'(k) - SEL_W'(1);
      nAddrWe[k] = 1'b0;
      nCntWe[k]  = 1'b0;
      nAddr[k]   = '0;
      nCnt[k]    = '0;
      if (strb.fire) begin
        if (strb.rotate) begin
          nCntWe[k] = 1'b1;
          if (rel != SEL_W'(1)) begin
            nAddrWe[k] = 1'b1;
            nAddr[k]   = addrIn[src];
            nCnt[k]    = cntIn[src];
          end
        end else if (rel == '0) begin
          nAddrWe[k] = 1'b1;
          nCntWe[k]  = 1'b1;
          nAddr[k]   = addrIn[HOLD_CH];
          nCnt[k]    = cntIn[HOLD_CH];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrWe <= '0;
      cntWe  <= '0;
      for (int k = 0; k < NUM_CH; k++) begin
        addrQ[k] <= '0;
        cntQ[k]  <= '0;
      end
    end else begin
      addrWe <= nAddrWe;
      cntWe  <= nCntWe;
      for (int k = 0; k < NUM_CH; k++) begin
        addrQ[k] <= nAddr[k];
        cntQ[k]  <= nCnt[k];
      end
    end
  end

  AST_COPY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.fire && !strb.rotate) |-> ($countones(cntWe) == 1 && addrWe == cntWe)); // R4

  AST_RING_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.fire && strb.rotate) |->
      (cntQ[SEL_W'($past(strb.sel) + SEL_W'(1))] == '0 && $countones(addrWe) == 3)); // R6
endmodule

// File: rtl/dma_chain_reload.sv
module dma_chain_reload
  import dma_chain_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int CHAIN_EN  = 1,
  parameter int ROTATE_EN = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 doneValid,
  input  logic [1:0]           doneChan,
  input  logic [3:0]           chainCtrl,
  input  logic [4*AW-1:0]      addrFlat,
  input  logic [4*CW-1:0]      cntFlat,
  output logic [3:0]           addrWe,
  output logic [4*AW-1:0]      addrWr,
  output logic [3:0]           cntWe,
  output logic [4*CW-1:0]      cntWr
);
  chainStrb_t strb;

  dma_chain_ctrl #(.CW(CW), .CHAIN_EN(CHAIN_EN), .ROTATE_EN(ROTATE_EN)) u_ctrl (
    .doneValid(doneValid), .doneChan(doneChan), .chainCtrl(chainCtrl),
    .cntFlat(cntFlat), .strb(strb)
  );

  dma_chain_dpath #(.AW(AW), .CW(CW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .addrFlat(addrFlat), .cntFlat(cntFlat),
    .addrWe(addrWe), .addrWr(addrWr), .cntWe(cntWe), .cntWr(cntWr)
  );

  AST_WRITE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (|cntWe) |-> $past(doneValid && chainCtrl[CTL_ARM] && cntFlat[doneChan*CW +: CW] == '0)); // R3

  AST_NO_RING_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (ROTATE_EN == 0) |-> ($countones(addrWe) <= 1)); // R8

  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (CHAIN_EN == 0) |-> (cntWe == '0 && addrWe == '0)); // R9
endmodule

// File: tb/dma_chain_reload_tb.sv
module dma_chain_reload_tb;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic doneValid = 1'b0;
  logic [1:0] doneChan = '0;
  logic [3:0] chainCtrl = '0;
  logic [4*AW-1:0] addrFlat = '0;
  logic [4*CW-1:0] cntFlat = '0;

  logic [3:0] aWe [3];
  logic [3:0] cWe [3];
  logic [4*AW-1:0] aWr [3];
  logic [4*CW-1:0] cWr [3];

  always #4 clk = ~clk;

  dma_chain_reload #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rstN(rstN), .doneValid(doneValid), .doneChan(doneChan),
    .chainCtrl(chainCtrl), .addrFlat(addrFlat), .cntFlat(cntFlat),
    .addrWe(aWe[0]), .addrWr(aWr[0]), .cntWe(cWe[0]), .cntWr(cWr[0]));
  dma_chain_reload #(.AW(AW), .CW(CW), .ROTATE_EN(0)) u_dutNoRing (
    .clk(clk), .rstN(rstN), .doneValid(doneValid), .doneChan(doneChan),
    .chainCtrl(chainCtrl), .addrFlat(addrFlat), .cntFlat(cntFlat),
    .addrWe(aWe[1]), .addrWr(aWr[1]), .cntWe(cWe[1]), .cntWr(cWr[1]));
  dma_chain_reload #(.AW(AW), .CW(CW), .CHAIN_EN(0)) u_dutOff (
    .clk(clk), .rstN(rstN), .doneValid(doneValid), .doneChan(doneChan),
    .chainCtrl(chainCtrl), .addrFlat(addrFlat), .cntFlat(cntFlat),
    .addrWe(aWe[2]), .addrWr(aWr[2]), .cntWe(cWe[2]), .cntWr(cWr[2]));

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // expected results per instance, for the cycle after the current inputs
  logic [3:0] expAWe [3];
  logic [3:0] expCWe [3];
  int unsigned expA [3][4];
  int unsigned expC [3][4];
  string expTag [3];

  function automatic int unsigned fldA(int k); return int'(addrFlat[k*AW +: AW]); endfunction
  function automatic int unsigned fldC(int k); return int'(cntFlat[k*CW +: CW]); endfunction

  // behavioural model of one chaining decision
  task automatic model(input int idx, input bit chainOn, input bit ringOn);
    int s, p3, p2, p1;
    expAWe[idx] = '0; expCWe[idx] = '0;
    for (int k = 0; k < 4; k++) begin expA[idx][k] = 0; expC[idx][k] = 0; end
    if (!chainOn) expTag[idx] = "R9";
    else if (!doneValid) expTag[idx] = "R2";
    else expTag[idx] = "R3";
    if (rstN && chainOn && doneValid && chainCtrl[0] && fldC(int'(doneChan)) == 0) begin
      s = int'(chainCtrl[2:1]);
      if (ringOn && chainCtrl[3]) begin
        p3 = (s + 3) % 4; p2 = (s + 2) % 4; p1 = (s + 1) % 4;
        expA[idx][s]  = fldA(p3); expC[idx][s]  = fldC(p3);
        expA[idx][p3] = fldA(p2); expC[idx][p3] = fldC(p2);
        expA[idx][p2] = fldA(p1); expC[idx][p2] = fldC(p1);
        expC[idx][p1] = 0;
        expAWe[idx][s] = 1; expAWe[idx][p3] = 1; expAWe[idx][p2] = 1;
        expCWe[idx] = 4'hF;
        expTag[idx] = "R5 R6 R7";
      end else begin
        expA[idx][s] = fldA(3); expC[idx][s] = fldC(3);
        expAWe[idx][s] = 1; expCWe[idx][s] = 1;
        expTag[idx] = (chainCtrl[3] && !ringOn) ? "R8" : "R4 R7";
      end
    end
  endtask

  task automatic compare(input int idx);
    total++;
    if (aWe[idx] !== expAWe[idx] || cWe[idx] !== expCWe[idx]) begin
      bad++;
      $display("FAIL %s inst%0d strobes addrWe=%b cntWe=%b expected %b %b",
               expTag[idx], idx, aWe[idx], cWe[idx], expAWe[idx], expCWe[idx]);
    end
    for (int k = 0; k < 4; k++) begin
      if (expAWe[idx][k]) begin
        total++;
        if (int'(aWr[idx][k*AW +: AW]) != expA[idx][k]) begin
          bad++;
          $display("FAIL %s inst%0d addr ch%0d got %h expected %h", expTag[idx], idx, k,
                   aWr[idx][k*AW +: AW], expA[idx][k]);
        end
      end
      if (expCWe[idx][k]) begin
        total++;
        if (int'(cWr[idx][k*CW +: CW]) != expC[idx][k]) begin
          bad++;
          $display("FAIL %s inst%0d count ch%0d got %h expected %h", expTag[idx], idx, k,
                   cWr[idx][k*CW +: CW], expC[idx][k]);
        end
      end
    end
  endtask

  task automatic randRegs(input bit manyZero);
    for (int k = 0; k < 4; k++) begin
      addrFlat[k*AW +: AW] = AW'($urandom);
      cntFlat[k*CW +: CW]  = (manyZero && ($urandom % 3 == 0)) ? '0 : CW'($urandom | 1);
    end
  endtask

  // one cycle: check outputs from the previous inputs, then apply new ones
  task automatic step(input bit v, input logic [1:0] ch, input logic [3:0] ctl, input bit zeroDone);
    @(negedge clk);
    for (int i = 0; i < 3; i++) compare(i);
    doneValid = v; doneChan = ch; chainCtrl = ctl;
    randRegs(1'b1);
    if (zeroDone) cntFlat[int'(ch)*CW +: CW] = '0;
    model(0, 1, 1); model(1, 1, 0); model(2, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      expAWe[i] = '0; expCWe[i] = '0; expTag[i] = "R1";
      for (int k = 0; k < 4; k++) begin expA[i][k] = 0; expC[i][k] = 0; end
    end
    // R1: reset holds strobes low even with an armed pulse present
    doneValid = 1; chainCtrl = 4'b0001; cntFlat = '0;
    repeat (3) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) compare(i);
    end
    doneValid = 0;
    @(negedge clk);
    rstN = 1;
    for (int i = 0; i < 3; i++) begin expTag[i] = "R1"; expAWe[i] = '0; expCWe[i] = '0; end
    // R2: idle cycles
    repeat (4) step(0, 2'd0, 4'b1001, 1);
    // R4 and R5/R6: sweep every chain channel and finishing channel in both patterns
    for (int ring = 0; ring < 2; ring++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 4; c++) begin
          step(1, 2'(c), {1'(ring), 2'(s), 1'b1}, 1);
          step(0, 2'(c), 4'b0000, 0);
        end
    // R3: arm bit clear, and nonzero count on the finishing channel
    for (int s = 0; s < 4; s++) begin
      step(1, 2'(s), {1'b1, 2'(s), 1'b0}, 1);
      @(negedge clk);
      for (int i = 0; i < 3; i++) compare(i);
      doneValid = 1; doneChan = 2'(s); chainCtrl = {1'b1, 2'(s), 1'b1};
      randRegs(1'b0);
      model(0, 1, 1); model(1, 1, 0); model(2, 0, 0);
    end
    // R7: back-to-back pulses with wrap-around chain channels
    for (int s = 0; s < 4; s++) begin
      step(1, 2'(3 - s), {1'b1, 2'(s), 1'b1}, 1);
      step(1, 2'(s), {1'b0, 2'(3 - s), 1'b1}, 1);
      step(1, 2'(s), {1'b1, 2'(3 - s), 1'b1}, 1);
    end
    // mixed random traffic
    repeat (2500) step(1'($urandom), 2'($urandom), 4'($urandom), 1'($urandom));
    step(0, 2'd0, 4'b0000, 0);
    step(0, 2'd0, 4'b0000, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule